// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block holds the burst configuration of a synchronous memory device and turns a starting column into the column address of every beat of a burst. A mode-load strobe carries a 15-bit configuration word. The block keeps the word only when its two bank-select bits are both zero, which marks the base configuration register. From that word it decodes the burst length, the burst ordering, the access latency and the operating mode. A word whose fields use a reserved code raises an error flag and leaves the held configuration unchanged.

A burst-start strobe samples a starting column. From the next cycle the block issues one registered column address per clock. It does this for as many beats as the held length calls for, and the final beat carries a last flag. The bits of the column above log2(length) stay fixed, so the burst stays inside an aligned block of that size. The low bits either count upward with wrap-around or follow the start offset XOR the beat index. A controller uses the address stream to drive its column bus, and it reads the decoded latency and mode fields for its own timing.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the block reports a burst length of 2, sequential order, a latency of 2 (cfg_lat_x2 = 4), no DLL-reset request, mode_err = 0, and col_valid = col_last = 0.
- R2: A mode load is taken only when mode_word[14:13] = 00. Any other bank value leaves every configuration output and mode_err unchanged.
- R3: Length code mode_word[2:0]: 001 gives 2 beats, 010 gives 4 and 011 gives 8. cfg_burst_len shows the beat count one cycle after the load. Every other code is reserved.
- R4: mode_word[3] picks the order. 0 is sequential and 1 is interleaved, shown on cfg_interleaved.
- R5: Latency code mode_word[6:4]: 010 gives latency 2 (cfg_lat_x2 = 4) and 110 gives latency 2.5 (cfg_lat_x2 = 5). Every other code is reserved.
- R6: Operating bits mode_word[12:7]: all zero means normal operation (cfg_dll_rst = 0). Only bit 8 set means normal operation with DLL reset (cfg_dll_rst = 1). Every other value is reserved.
- R7: A base load with any reserved field sets mode_err one cycle later and keeps the whole previous configuration. A later fully valid base load clears mode_err.
- R8: A burst_start at a clock edge shows col_valid = 1 with col_out = start_col after that edge. Then length-1 further beats follow in consecutive cycles. In every beat, the bits above log2(length) equal those of start_col.
- R9: In sequential order, beat k carries the low offset (s + k) mod N, where s is the start offset inside the N-element block.
- R10: In interleaved order, beat k carries the low offset s XOR k.
- R11: col_last is 1 on the Nth beat only. col_valid falls in the cycle after it unless a new burst starts.
- R12: A burst_start during a burst aborts the old one. Beat 0 of the new burst appears in the next cycle.
- R13: A burst runs with the length and order held at its start edge. A mode load during the burst, or on the same edge as the start, does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Configuration word strobe |
| mode_word | input | 15 | Configuration word, bank select in [14:13] |
| burst_start | input | 1 | Start a burst at start_col |
| start_col | input | COL_W | Starting column |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | col_out carries a beat |
| col_last | output | 1 | Current beat is the final one |
| mode_err | output | 1 | Last base load had a reserved field |
| cfg_burst_len | output | 4 | Held beat count (2, 4 or 8) |
| cfg_interleaved | output | 1 | Held order, 1 = interleaved |
| cfg_lat_x2 | output | 3 | Held latency times two |
| cfg_dll_rst | output | 1 | Held DLL-reset request |

## Verification
The bench builds the block with its default 10-bit column. Random starting columns therefore reach the upper block bits, and the bench can confirm that these bits never move across a wrap. All three lengths and both orders are tried with every start offset that the random stream reaches. Directed cases cover offset 5 in a burst of 8 in both orders, a restart in mid-burst, a configuration change in mid-burst, and loads aimed at the extended register.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int MODE_W = 15;
  localparam int OFS_W  = 3;

  typedef struct packed {
    logic [1:0] bl_log;
    logic       ilv;
    logic       lat_half;
    logic       dll_rst;
  } bcs_cfg_t;

  localparam bcs_cfg_t CFG_RESET = '{bl_log: 2'd1, ilv: 1'b0, lat_half: 1'b0, dll_rst: 1'b0};

  function automatic logic [OFS_W-1:0] len_mask(input logic [1:0] bl_log);
    logic [OFS_W-1:0] m;
    m = '0;
    for (int i = 0; i < OFS_W; i++) begin
      if (i < int'(bl_log)) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output bcs_cfg_t          cfg,
  output logic              err
);
  logic       is_base;
  logic       len_ok, lat_ok, op_ok;
  bcs_cfg_t   cfg_new;

  assign is_base = (word[14:13] == 2'b00);

  always_comb begin
    cfg_new = cfg;
    len_ok  = 1'b1;
    lat_ok  = 1'b1;
    op_ok   = 1'b1;
    case (word[2:0])
      3'b001:  cfg_new.bl_log = 2'd1;
      3'b010:  cfg_new.bl_log = 2'd2;
      3'b011:  cfg_new.bl_log = 2'd3;
      default: len_ok = 1'b0;
    endcase
    cfg_new.ilv = word[3];
    case (word[6:4])
      3'b010:  cfg_new.lat_half = 1'b0;
      3'b110:  cfg_new.lat_half = 1'b1;
      default: lat_ok = 1'b0;
    endcase
    case (word[12:7])
      6'b000000: cfg_new.dll_rst = 1'b0;
      6'b000010: cfg_new.dll_rst = 1'b1;
      default:   op_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
      err <= 1'b0;
    end else if (load && is_base) begin
      if (len_ok && lat_ok && op_ok) begin
        cfg <= cfg_new;
        err <= 1'b0;
      end else begin
        err <= 1'b1;
      end
    end
  end

  assert_ext_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (load && !is_base) |=> (cfg == $past(cfg)) && (err == $past(err)));

  assert_reserved_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (load && is_base && !(len_ok && lat_ok && op_ok)) |=> (cfg == $past(cfg)) && err);

  assert_valid_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (load && is_base && len_ok && lat_ok && op_ok) |=> !err);

  assert_len_legal_R3: assert property (@(posedge clk) disable iff (rst)
    cfg.bl_log != 2'd0);
endmodule

// File: rtl/bcs_offset.sv
module bcs_offset
  import bcs_pkg::*;
(
  input  logic [OFS_W-1:0] start_low,
  input  logic [OFS_W-1:0] beat,
  input  logic [1:0]       bl_log,
  input  logic             ilv,
  output logic [OFS_W-1:0] ofs
);
  logic [OFS_W-1:0] mask, sum, flip;

  assign mask = len_mask(bl_log);
  assign sum  = start_low + beat;
  assign flip = start_low ^ beat;

  for (genvar b = 0; b < OFS_W; b++) begin : g_bit
    assign ofs[b] = mask[b] ? (ilv ? flip[b] : sum[b]) : start_low[b];
  end
endmodule

// File: rtl/bcs_beat_ctl.sv
module bcs_beat_ctl
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       bl_log,
  input  logic             ilv,
  output logic [COL_W-1:0] col,
  output logic             vld,
  output logic             last
);
  localparam int HI_W = COL_W - OFS_W;

  logic             act;
  logic [OFS_W-1:0] beat;
  logic [COL_W-1:0] base;
  logic [1:0]       bl_log_q;
  logic             ilv_q;
  logic [OFS_W-1:0] mask_q;
  logic [OFS_W-1:0] ofs;

  assign mask_q = len_mask(bl_log_q);

  bcs_offset u_ofs (
    .start_low (base[OFS_W-1:0]),
    .beat      (beat),
    .bl_log    (bl_log_q),
    .ilv       (ilv_q),
    .ofs       (ofs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= 1'b0;
      beat     <= '0;
      base     <= '0;
      bl_log_q <= 2'd1;
      ilv_q    <= 1'b0;
      col      <= '0;
      vld      <= 1'b0;
      last     <= 1'b0;
    end else if (start) begin
      act      <= 1'b1;
      beat     <= OFS_W'(1);
      base     <= start_col;
      bl_log_q <= bl_log;
      ilv_q    <= ilv;
      col      <= start_col;
      vld      <= 1'b1;
      last     <= 1'b0;
    end else if (act) begin
      col  <= {base[COL_W-1:OFS_W], ofs};
      vld  <= 1'b1;
      last <= (beat == mask_q);
      act  <= (beat != mask_q);
      beat <= beat + OFS_W'(1);
    end else begin
      vld  <= 1'b0;
      last <= 1'b0;
    end
  end

  assert_start_beat0_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> vld && !last && (col == $past(start_col)));

  assert_block_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (vld && !last && !start) |=> vld && (col[COL_W-1:OFS_W] == $past(col[COL_W-1:OFS_W])));

  assert_last_valid_R11: assert property (@(posedge clk) disable iff (rst)
    last |-> vld);

  assert_after_last_R11: assert property (@(posedge clk) disable iff (rst)
    (last && !start) |=> !vld);

  initial begin
    assert_col_width: assert (HI_W >= 1);
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_load,
  input  logic [14:0]      mode_word,
  input  logic             burst_start,
  input  logic [COL_W-1:0] start_col,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic             mode_err,
  output logic [3:0]       cfg_burst_len,
  output logic             cfg_interleaved,
  output logic [2:0]       cfg_lat_x2,
  output logic             cfg_dll_rst
);
  bcs_cfg_t cfg;

  bcs_mode_reg u_mode (
    .clk  (clk),
    .rst  (rst),
    .load (mode_load),
    .word (mode_word),
    .cfg  (cfg),
    .err  (mode_err)
  );

  bcs_beat_ctl #(.COL_W(COL_W)) u_beat (
    .clk       (clk),
    .rst       (rst),
    .start     (burst_start),
    .start_col (start_col),
    .bl_log    (cfg.bl_log),
    .ilv       (cfg.ilv),
    .col       (col_out),
    .vld       (col_valid),
    .last      (col_last)
  );

  assign cfg_burst_len   = 4'd1 << cfg.bl_log;
  assign cfg_interleaved = cfg.ilv;
  assign cfg_lat_x2      = cfg.lat_half ? 3'd5 : 3'd4;
  assign cfg_dll_rst     = cfg.dll_rst;
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mode_load = 1'b0;
  logic [14:0]      mode_word = '0;
  logic             burst_start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [COL_W-1:0] col_out;
  logic             col_valid, col_last, mode_err;
  logic [3:0]       cfg_burst_len;
  logic             cfg_interleaved;
  logic [2:0]       cfg_lat_x2;
  logic             cfg_dll_rst;

  int checks = 0;
  int errors = 0;

  int m_len = 2;
  bit m_ilv = 1'b0;
  int m_lat = 4;
  bit m_dll = 1'b0;
  bit m_err = 1'b0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_word(mode_word),
    .burst_start(burst_start), .start_col(start_col), .col_out(col_out),
    .col_valid(col_valid), .col_last(col_last), .mode_err(mode_err),
    .cfg_burst_len(cfg_burst_len), .cfg_interleaved(cfg_interleaved),
    .cfg_lat_x2(cfg_lat_x2), .cfg_dll_rst(cfg_dll_rst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] mk(input int bank, input int op, input int lat, input int bt, input int bl);
    return {2'(bank), 6'(op), 3'(lat), 1'(bt), 3'(bl)};
  endfunction

  function automatic int exp_col(input int s, input int k, input int n, input bit ilv);
    int lo;
    lo = s % n;
    if (ilv) return (s - lo) + (lo ^ k);
    return (s - lo) + ((lo + k) % n);
  endfunction

  task automatic check_cfg(input string tag);
    chk({tag, " len R3"}, cfg_burst_len, m_len);
    chk({tag, " ilv R4"}, cfg_interleaved, m_ilv);
    chk({tag, " lat R5"}, cfg_lat_x2, m_lat);
    chk({tag, " dll R6"}, cfg_dll_rst, m_dll);
    chk({tag, " err R7"}, mode_err, m_err);
  endtask

  task automatic model_load(input logic [14:0] w);
    int n, l;
    bit ok;
    if (w[14:13] != 2'b00) return;
    ok = 1'b1;
    n = 0;
    l = 0;
    case (w[2:0]) 3'd1: n = 2; 3'd2: n = 4; 3'd3: n = 8; default: ok = 1'b0; endcase
    case (w[6:4]) 3'd2: l = 4; 3'd6: l = 5; default: ok = 1'b0; endcase
    if (w[12:7] != 6'd0 && w[12:7] != 6'd2) ok = 1'b0;
    if (ok) begin
      m_len = n; m_ilv = w[3]; m_lat = l; m_dll = (w[12:7] == 6'd2); m_err = 1'b0;
    end else begin
      m_err = 1'b1;
    end
  endtask

  task automatic load_mode(input logic [14:0] w, input string tag);
    @(negedge clk);
    mode_load = 1'b1;
    mode_word = w;
    model_load(w);
    @(negedge clk);
    mode_load = 1'b0;
    check_cfg(tag);
  endtask

  task automatic run_burst(input int s);
    int n;
    bit ilv;
    n = m_len;
    ilv = m_ilv;
    @(negedge clk);
    burst_start = 1'b1;
    start_col = COL_W'(s);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      burst_start = 1'b0;
      chk(k == 0 ? "beat0 R8" : (ilv ? "order R10" : "order R9"), col_out, exp_col(s, k, n, ilv));
      chk("valid R8", col_valid, 1);
      chk("last R11", col_last, (k == n - 1));
    end
    @(negedge clk);
    chk("drop R11", col_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_cfg("reset R1");
    chk("reset valid R1", col_valid, 0);
    chk("reset last R1", col_last, 0);

    // R3 R9: burst of 8, sequential, start offset 5
    load_mode(mk(0, 0, 2, 0, 3), "load8seq");
    run_burst(10'h2D5 & 10'h3FD);
    run_burst(10'h1A5);
    // R10: interleaved, offset 5
    load_mode(mk(0, 2, 6, 1, 3), "load8ilv");
    run_burst(10'h1A5);
    // R2: extended register ignored
    load_mode(mk(1, 0, 2, 0, 1), "ext R2");
    load_mode(mk(2, 5, 7, 0, 0), "ext R2");
    load_mode(mk(3, 0, 2, 0, 2), "ext R2");
    // R7: reserved codes keep config
    load_mode(mk(0, 0, 2, 0, 4), "resv len R7");
    load_mode(mk(0, 0, 3, 0, 2), "resv lat R7");
    load_mode(mk(0, 4, 2, 0, 2), "resv op R7");
    run_burst(10'h0F3);
    load_mode(mk(0, 0, 2, 0, 2), "clear R7");
    run_burst(10'h0F3);

    // R12: restart mid-burst
    load_mode(mk(0, 0, 2, 0, 3), "load8seq");
    @(negedge clk);
    burst_start = 1'b1; start_col = 10'h106;
    @(negedge clk);
    chk("restart first R12", col_out, 10'h106);
    start_col = 10'h3F1;
    @(negedge clk);
    burst_start = 1'b0;
    chk("restart beat0 R12", col_out, 10'h3F1);
    chk("restart last R12", col_last, 0);
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      chk("restart seq R12", col_out, exp_col(10'h3F1, k, 8, 1'b0));
      chk("restart lastk R12", col_last, (k == 7));
    end
    @(negedge clk);
    chk("restart drop R12", col_valid, 0);

    // R13: load on the start edge and in mid-burst
    @(negedge clk);
    burst_start = 1'b1; start_col = 10'h0CA;
    mode_load = 1'b1; mode_word = mk(0, 0, 2, 1, 1);
    @(negedge clk);
    burst_start = 1'b0; mode_load = 1'b0;
    chk("same edge beat0 R13", col_out, 10'h0CA);
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      if (k == 2) begin mode_load = 1'b1; mode_word = mk(0, 0, 6, 0, 2); end
      else mode_load = 1'b0;
      chk("mid load seq R13", col_out, exp_col(10'h0CA, k, 8, 1'b0));
      chk("mid load last R13", col_last, (k == 7));
    end
    mode_load = 1'b0;
    model_load(mk(0, 0, 2, 1, 1));
    model_load(mk(0, 0, 6, 0, 2));
    @(negedge clk);
    check_cfg("after R13");

    // random mix
    for (int i = 0; i < 60; i++) begin
      int bank, op, lat, bl;
      bank = ($urandom % 6 == 0) ? 1 + $urandom % 3 : 0;
      op   = ($urandom % 8 == 0) ? $urandom % 64 : (($urandom % 2) ? 2 : 0);
      lat  = ($urandom % 8 == 0) ? $urandom % 8 : (($urandom % 2) ? 6 : 2);
      bl   = ($urandom % 8 == 0) ? $urandom % 8 : 1 + $urandom % 3;
      load_mode(mk(bank, op, lat, $urandom % 2, bl), bank != 0 ? "rand R2" : "rand");
      for (int j = 0; j < 3; j++) begin
        s = $urandom % (1 << COL_W);
        run_burst(s);
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule